// File: doc/BRIEF.md
# Pipelined Multiply-Accumulate Unit

This block multiplies two 32-bit integers and either deposits the product into a 64-bit accumulator (split into a high and a low word) or returns its low word on a general-register result port. Besides a plain multiply into the accumulator it can add the product to the accumulator or subtract it, in signed or unsigned form. One operation is offered per clock on an issue strobe together with an opcode, a signedness flag and the two operands.

The multiplier array is only 33x17 bits wide. When the second operand is a pure sign or zero extension of its low 16 bits, the product is formed in one pass and a new operation may follow on the very next clock. Otherwise the array is used twice in the second stage, and the unit raises `busy` for that one extra clock. An issue offered while `busy` is high is dropped. The partial products are merged with each other and with the accumulator in a separate third stage, so back-to-back accumulations chain directly on the freshly written accumulator.

Top module: `mac_unit`

## Requirements
- R1: While reset is asserted and right after it is released, `acc_hi` and `acc_lo` are zero and `busy` and `gpr_vld` are low.
- R2: Opcode 0 writes the product to the accumulator. For a single-pass operation accepted at clock edge n, the new value is visible after edge n+2.
- R3: A single-pass operation never raises `busy`, so single-pass operations can be accepted on every consecutive clock edge.
- R4: An accepted two-pass operation raises `busy` for exactly the one cycle after its acceptance edge. Its result is visible after edge n+3.
- R5: An issue offered while `busy` is high is ignored and leaves the accumulator and the result port unchanged.
- R6: Opcode 1 adds the product to the accumulator, modulo 2^64.
- R7: Opcode 2 subtracts the product from the accumulator, modulo 2^64.
- R8: Opcode 3 pulses `gpr_vld` high for one cycle, with `gpr_data` holding the low 32 bits of the product. It leaves the accumulator unchanged and appears with the same latency as an accumulator result.
- R9: With `is_signed`=1, both operands are two's complement and the second operand is single-pass when its bits 31..15 are all equal. With `is_signed`=0, both operands are unsigned and the second operand is single-pass when its bits 31..16 are zero.
- R10: Accumulate operations accepted back to back, including a mix of single-pass and two-pass ones, each act on the result of the operation before them.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| issue_vld | input | 1 | Offers an operation this cycle |
| op | input | 2 | 0 load product, 1 add, 2 subtract, 3 register-result multiply |
| is_signed | input | 1 | 1 = two's complement operands, 0 = unsigned |
| src_a | input | 32 | First operand |
| src_b | input | 32 | Second operand (decides one or two passes) |
| busy | output | 1 | High while the array makes its second pass; issues are dropped |
| gpr_vld | output | 1 | One-cycle strobe for a register-result multiply |
| gpr_data | output | 32 | Low product word of the last register-result multiply |
| acc_hi | output | 32 | Accumulator bits 63..32 |
| acc_lo | output | 32 | Accumulator bits 31..0 |

## Verification
For an operation accepted on edge n, the accumulator or result strobe is due after edge n+2 on the single-pass path and after edge n+3 on the two-pass path. `busy` is due only in the cycle between edges n and n+1. The bench model keeps every accepted operation with its own due cycle and retires it at that edge. It judges acceptance from its own view of `busy`, so dropped issues never enter it. All outputs are compared one nanosecond after each rising edge, which is the point where every register on the path has settled.

// File: rtl/mac_pkg.sv
package mac_pkg;
   typedef enum logic [1:0] {
      MAC_LOAD = 2'd0,
      MAC_ADD  = 2'd1,
      MAC_SUB  = 2'd2,
      MAC_GPR  = 2'd3
   } mac_op_e;
endpackage

// File: rtl/mac_issue_ctl.sv
module mac_issue_ctl
   import mac_pkg::*;
#(
   parameter int DATA_W  = 32,
   parameter int SLICE_W = 16
)(
   input  logic              clk,
   input  logic              rst_n,
   input  logic              issue_vld,
   input  logic [1:0]        op,
   input  logic              is_signed,
   input  logic [DATA_W-1:0] src_a,
   input  logic [DATA_W-1:0] src_b,
   output logic              busy,
   output logic              adv,
   output logic              m_vld,
   output mac_op_e           m_op,
   output logic              m_sgn,
   output logic              m_wide,
   output logic              m_pass,
   output logic [DATA_W-1:0] m_a,
   output logic [DATA_W-1:0] m_b
);
   localparam int EXT_W = DATA_W - SLICE_W;

   if (DATA_W != 2 * SLICE_W) begin : g_bad_split
      $error("mac_issue_ctl: DATA_W must be twice SLICE_W");
   end

   logic              accept;
   logic              fits;
   logic [EXT_W:0]    sgn_field;
   logic [EXT_W-1:0]  uns_field;

   assign sgn_field = src_b[DATA_W-1:SLICE_W-1];
   assign uns_field = src_b[DATA_W-1:SLICE_W];
   assign fits      = is_signed ? ((&sgn_field) | ~(|sgn_field)) : ~(|uns_field);

   assign busy   = m_vld & m_wide & ~m_pass;
   assign adv    = m_vld & ~busy;
   assign accept = issue_vld & ~busy;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         m_vld  <= 1'b0;
         m_pass <= 1'b0;
         m_op   <= MAC_LOAD;
         m_sgn  <= 1'b0;
         m_wide <= 1'b0;
         m_a    <= '0;
         m_b    <= '0;
      end else if (busy) begin
         m_pass <= 1'b1;
      end else begin
         m_vld  <= accept;
         m_pass <= 1'b0;
         if (accept) begin
            m_op   <= mac_op_e'(op);
            m_sgn  <= is_signed;
            m_wide <= ~fits;
            m_a    <= src_a;
            m_b    <= src_b;
         end
      end
   end
endmodule

// File: rtl/mac_pp_array.sv
module mac_pp_array #(
   parameter int A_W   = 33,
   parameter int B_W   = 17,
   parameter int STYLE = 0,
   localparam int P_W  = A_W + B_W
)(
   input  logic signed [A_W-1:0] a_op,
   input  logic signed [B_W-1:0] b_op,
   output logic signed [P_W-1:0] prod
);
   if (STYLE != 0 && STYLE != 1) begin : g_bad_style
      $error("mac_pp_array: STYLE must be 0 or 1");
   end

   if (STYLE == 0) begin : g_operator
      assign prod = a_op * b_op;
   end else begin : g_rows
      logic signed [P_W-1:0] a_ext;
      logic signed [P_W-1:0] rows [B_W];
      assign a_ext = P_W'(a_op);
      for (genvar i = 0; i < B_W - 1; i++) begin : g_row
         assign rows[i] = b_op[i] ? (a_ext <<< i) : '0;
      end
      assign rows[B_W-1] = b_op[B_W-1] ? ('0 - (a_ext <<< (B_W - 1))) : '0;
      always_comb begin
         prod = '0;
         for (int k = 0; k < B_W; k++) begin
            prod = prod + rows[k];
         end
      end
   end
endmodule

// File: rtl/mac_cpa_acc.sv
module mac_cpa_acc
   import mac_pkg::*;
#(
   parameter int DATA_W  = 32,
   parameter int SLICE_W = 16,
   parameter int PP_W    = 50,
   localparam int ACC_W  = 2 * DATA_W
)(
   input  logic                   clk,
   input  logic                   rst_n,
   input  logic                   a_vld,
   input  mac_op_e                a_op,
   input  logic signed [PP_W-1:0] a_pp0,
   input  logic signed [PP_W-1:0] a_pp1,
   output logic                   gpr_vld,
   output logic [DATA_W-1:0]      gpr_data,
   output logic [DATA_W-1:0]      acc_hi,
   output logic [DATA_W-1:0]      acc_lo
);
   if (PP_W > ACC_W) begin : g_bad_pp
      $error("mac_cpa_acc: partial product wider than accumulator");
   end

   logic [ACC_W-1:0] acc_q;
   logic [ACC_W-1:0] acc_d;
   logic [ACC_W-1:0] ext0;
   logic [ACC_W-1:0] ext1;
   logic [ACC_W-1:0] prod;

   assign ext0 = ACC_W'(a_pp0);
   assign ext1 = ACC_W'(a_pp1);
   assign prod = ext0 + (ext1 << SLICE_W);

   always_comb begin
      unique case (a_op)
         MAC_LOAD: acc_d = prod;
         MAC_ADD:  acc_d = acc_q + prod;
         MAC_SUB:  acc_d = acc_q - prod;
         default:  acc_d = acc_q;
      endcase
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         acc_q    <= '0;
         gpr_vld  <= 1'b0;
         gpr_data <= '0;
      end else begin
         gpr_vld <= a_vld && (a_op == MAC_GPR);
         if (a_vld && (a_op != MAC_GPR)) begin
            acc_q <= acc_d;
         end
         if (a_vld && (a_op == MAC_GPR)) begin
            gpr_data <= prod[DATA_W-1:0];
         end
      end
   end

   assign acc_hi = acc_q[ACC_W-1:DATA_W];
   assign acc_lo = acc_q[DATA_W-1:0];
endmodule

// File: rtl/mac_unit.sv
module mac_unit
   import mac_pkg::*;
#(
   parameter int DATA_W      = 32,
   parameter int SLICE_W     = 16,
   parameter int ARRAY_STYLE = 0
)(
   input  logic              clk,
   input  logic              rst_n,
   input  logic              issue_vld,
   input  logic [1:0]        op,
   input  logic              is_signed,
   input  logic [DATA_W-1:0] src_a,
   input  logic [DATA_W-1:0] src_b,
   output logic              busy,
   output logic              gpr_vld,
   output logic [DATA_W-1:0] gpr_data,
   output logic [DATA_W-1:0] acc_hi,
   output logic [DATA_W-1:0] acc_lo
);
   localparam int A_W  = DATA_W + 1;
   localparam int B_W  = SLICE_W + 1;
   localparam int PP_W = A_W + B_W;

   logic              adv;
   logic              m_vld;
   mac_op_e           m_op;
   logic              m_sgn;
   logic              m_wide;
   logic              m_pass;
   logic [DATA_W-1:0] m_a;
   logic [DATA_W-1:0] m_b;

   mac_issue_ctl #(.DATA_W(DATA_W), .SLICE_W(SLICE_W)) u_issue (
      .clk       (clk),
      .rst_n     (rst_n),
      .issue_vld (issue_vld),
      .op        (op),
      .is_signed (is_signed),
      .src_a     (src_a),
      .src_b     (src_b),
      .busy      (busy),
      .adv       (adv),
      .m_vld     (m_vld),
      .m_op      (m_op),
      .m_sgn     (m_sgn),
      .m_wide    (m_wide),
      .m_pass    (m_pass),
      .m_a       (m_a),
      .m_b       (m_b)
   );

   logic signed [A_W-1:0]  arr_a;
   logic signed [B_W-1:0]  arr_b;
   logic signed [PP_W-1:0] arr_p;

   assign arr_a = {m_sgn & m_a[DATA_W-1], m_a};

   always_comb begin
      if (!m_wide) begin
         arr_b = m_b[SLICE_W:0];
      end else if (!m_pass) begin
         arr_b = {1'b0, m_b[SLICE_W-1:0]};
      end else begin
         arr_b = {m_sgn & m_b[DATA_W-1], m_b[DATA_W-1:SLICE_W]};
      end
   end

   mac_pp_array #(.A_W(A_W), .B_W(B_W), .STYLE(ARRAY_STYLE)) u_array (
      .a_op (arr_a),
      .b_op (arr_b),
      .prod (arr_p)
   );

   logic signed [PP_W-1:0] pp_hold;
   logic                   a_vld;
   mac_op_e                a_op;
   logic signed [PP_W-1:0] a_pp0;
   logic signed [PP_W-1:0] a_pp1;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         pp_hold <= '0;
         a_vld   <= 1'b0;
         a_op    <= MAC_LOAD;
         a_pp0   <= '0;
         a_pp1   <= '0;
      end else begin
         if (busy) begin
            pp_hold <= arr_p;
         end
         a_vld <= adv;
         if (adv) begin
            a_op  <= m_op;
            a_pp0 <= m_wide ? pp_hold : arr_p;
            a_pp1 <= m_wide ? arr_p : '0;
         end
      end
   end

   mac_cpa_acc #(.DATA_W(DATA_W), .SLICE_W(SLICE_W), .PP_W(PP_W)) u_cpa (
      .clk      (clk),
      .rst_n    (rst_n),
      .a_vld    (a_vld),
      .a_op     (a_op),
      .a_pp0    (a_pp0),
      .a_pp1    (a_pp1),
      .gpr_vld  (gpr_vld),
      .gpr_data (gpr_data),
      .acc_hi   (acc_hi),
      .acc_lo   (acc_lo)
   );
endmodule

// File: rtl/mac_unit_chk.sv
module mac_unit_chk #(
   parameter int DATA_W  = 32,
   parameter int SLICE_W = 16
)(
   input logic              clk,
   input logic              rst_n,
   input logic              issue_vld,
   input logic              is_signed,
   input logic [DATA_W-1:0] src_b,
   input logic              busy,
   input logic              gpr_vld,
   input logic [DATA_W-1:0] acc_hi,
   input logic [DATA_W-1:0] acc_lo
);
   logic b_fits;
   assign b_fits = is_signed
      ? ((&src_b[DATA_W-1:SLICE_W-1]) | ~(|src_b[DATA_W-1:SLICE_W-1]))
      : ~(|src_b[DATA_W-1:SLICE_W]);

   assert_reset_clear_R1: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(rst_n) |-> (acc_hi == '0 && acc_lo == '0 && !busy && !gpr_vld));

   assert_single_no_busy_R3: assert property (@(posedge clk) disable iff (!rst_n)
      (issue_vld && !busy && b_fits) |=> !busy);

   assert_busy_one_cycle_R4: assert property (@(posedge clk) disable iff (!rst_n)
      busy |=> !busy);

   assert_busy_from_accept_R4: assert property (@(posedge clk) disable iff (!rst_n)
      busy |-> $past(issue_vld && !busy && !b_fits));

   assert_gpr_keeps_acc_R8: assert property (@(posedge clk) disable iff (!rst_n)
      gpr_vld |-> $stable({acc_hi, acc_lo}));
endmodule

bind mac_unit mac_unit_chk #(.DATA_W(DATA_W), .SLICE_W(SLICE_W)) u_chk (
   .clk       (clk),
   .rst_n     (rst_n),
   .issue_vld (issue_vld),
   .is_signed (is_signed),
   .src_b     (src_b),
   .busy      (busy),
   .gpr_vld   (gpr_vld),
   .acc_hi    (acc_hi),
   .acc_lo    (acc_lo)
);

// File: tb/sim_mac_unit.sv
module sim_mac_unit;
   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        issue_vld = 1'b0;
   logic [1:0]  op = 2'd0;
   logic        is_sgn = 1'b0;
   logic [31:0] src_a = '0;
   logic [31:0] src_b = '0;
   logic        busy;
   logic        gpr_vld;
   logic [31:0] gpr_data;
   logic [31:0] acc_hi;
   logic [31:0] acc_lo;

   int    n_tests = 0;
   int    n_fail  = 0;
   int    wd      = 0;
   string phase   = "R1";

   always #2 clk = ~clk;

   mac_unit u0 (
      .clk       (clk),
      .rst_n     (rst_n),
      .issue_vld (issue_vld),
      .op        (op),
      .is_signed (is_sgn),
      .src_a     (src_a),
      .src_b     (src_b),
      .busy      (busy),
      .gpr_vld   (gpr_vld),
      .gpr_data  (gpr_data),
      .acc_hi    (acc_hi),
      .acc_lo    (acc_lo)
   );

   task automatic chk(string req, string what, logic [63:0] act, logic [63:0] exp);
      n_tests++;
      if (act !== exp) begin
         n_fail++;
         $display("FAIL %s %s: actual %h expected %h", req, what, act, exp);
      end
   endtask

   function automatic bit single_pass(logic s, logic [31:0] b);
      if (s) return (b[31:15] == 17'h1FFFF) || (b[31:15] == 17'h0);
      return b[31:16] == 16'h0;
   endfunction

   function automatic logic [63:0] ref_prod(logic s, logic [31:0] a, logic [31:0] b);
      longint sa, sb;
      if (s) begin
         sa = longint'($signed(a));
         sb = longint'($signed(b));
         return 64'(sa * sb);
      end
      return {32'h0, a} * {32'h0, b};
   endfunction

   typedef struct {
      int          due;
      logic [1:0]  op;
      logic [63:0] p;
   } pend_t;

   pend_t       q[$];
   int          cyc = 0;
   logic [63:0] m_acc = '0;
   bit          m_busy = 1'b0;
   bit          m_gv = 1'b0;
   logic [31:0] m_gd = '0;

   always @(posedge clk) begin
      if (!rst_n) begin
         q.delete();
         cyc = 0; m_acc = '0; m_busy = 1'b0; m_gv = 1'b0; m_gd = '0;
      end else begin
         cyc++;
         m_gv = 1'b0;
         while (q.size() > 0 && q[0].due == cyc) begin
            pend_t e;
            e = q.pop_front();
            case (e.op)
               2'd0: m_acc = e.p;
               2'd1: m_acc = m_acc + e.p;
               2'd2: m_acc = m_acc - e.p;
               default: begin m_gv = 1'b1; m_gd = e.p[31:0]; end
            endcase
         end
         if (issue_vld && !m_busy) begin
            pend_t n;
            bit w;
            w = !single_pass(is_sgn, src_b);
            n.due = cyc + (w ? 3 : 2);
            n.op  = op;
            n.p   = ref_prod(is_sgn, src_a, src_b);
            q.push_back(n);
            m_busy = w;
         end else begin
            m_busy = 1'b0;
         end
      end
   end

   always @(posedge clk) begin
      #1;
      if (rst_n) begin
         chk(phase, "acc", {acc_hi, acc_lo}, m_acc);
         chk(phase, "busy", 64'(busy), 64'(m_busy));
         chk(phase, "gpr_vld", 64'(gpr_vld), 64'(m_gv));
         if (m_gv) chk(phase, "gpr_data", 64'(gpr_data), 64'(m_gd));
      end
   end

   task automatic issue(logic [1:0] o, logic s, logic [31:0] a, logic [31:0] b);
      @(negedge clk);
      issue_vld = 1'b1; op = o; is_sgn = s; src_a = a; src_b = b;
   endtask

   task automatic idle(int n);
      repeat (n) begin
         @(negedge clk);
         issue_vld = 1'b0;
      end
   endtask

   task automatic finish_run();
      $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
      $finish;
   endtask

   always @(posedge clk) begin
      wd++;
      if (wd > 100000) begin
         n_tests++;
         n_fail++;
         $display("FAIL watchdog: actual %0d expected below 100000 cycles", wd);
         finish_run();
      end
   end

   initial begin
      repeat (3) @(negedge clk);
      chk("R1", "acc in reset", {acc_hi, acc_lo}, 64'h0);
      chk("R1", "busy in reset", 64'(busy), 64'h0);
      chk("R1", "gpr_vld in reset", 64'(gpr_vld), 64'h0);
      rst_n = 1'b1;
      idle(2);
      chk("R1", "acc after reset", {acc_hi, acc_lo}, 64'h0);

      phase = "R2";
      issue(2'd0, 1'b0, 32'd100, 32'd200);
      idle(4);
      chk("R2", "load 100*200", {acc_hi, acc_lo}, 64'd20000);

      phase = "R6";
      issue(2'd1, 1'b1, 32'd3, 32'd4);
      idle(4);
      chk("R6", "add 3*4", {acc_hi, acc_lo}, 64'd20012);
      issue(2'd1, 1'b0, 32'hFFFF_FFFF, 32'd2);
      idle(4);
      chk("R6", "unsigned add", {acc_hi, acc_lo}, 64'h2_0000_4E2A);

      phase = "R7";
      issue(2'd0, 1'b0, 32'd5, 32'd1);
      idle(3);
      issue(2'd2, 1'b0, 32'd6, 32'd1);
      idle(4);
      chk("R7", "subtract wraps", {acc_hi, acc_lo}, 64'hFFFF_FFFF_FFFF_FFFF);
      issue(2'd2, 1'b1, 32'hFFFF_FFFE, 32'd3);
      idle(4);
      chk("R7", "signed subtract", {acc_hi, acc_lo}, 64'd5);

      phase = "R4";
      issue(2'd0, 1'b0, 32'h0001_0000, 32'h0001_0000);
      @(negedge clk); issue_vld = 1'b0;
      chk("R4", "busy after two-pass issue", 64'(busy), 64'h1);
      idle(4);
      chk("R4", "two-pass result", {acc_hi, acc_lo}, 64'h1_0000_0000);

      phase = "R9";
      issue(2'd0, 1'b1, 32'd7, 32'hFFFF_8000);
      @(negedge clk); issue_vld = 1'b0;
      chk("R9", "signed -32768 single pass", 64'(busy), 64'h0);
      idle(4);
      chk("R9", "7*-32768", {acc_hi, acc_lo}, 64'hFFFF_FFFF_FFFC_8000);
      issue(2'd0, 1'b0, 32'd7, 32'hFFFF_8000);
      @(negedge clk); issue_vld = 1'b0;
      chk("R9", "unsigned high b two pass", 64'(busy), 64'h1);
      idle(4);
      chk("R9", "unsigned 7*FFFF8000", {acc_hi, acc_lo}, 64'h6_FFFC_8000);
      issue(2'd0, 1'b1, 32'd7, 32'h0000_8000);
      @(negedge clk); issue_vld = 1'b0;
      chk("R9", "signed +32768 two pass", 64'(busy), 64'h1);
      idle(4);
      chk("R9", "7*32768", {acc_hi, acc_lo}, 64'h3_8000);

      phase = "R8";
      issue(2'd3, 1'b1, 32'hFFFF_FFFE, 32'h0001_2345);
      idle(5);
      chk("R8", "gpr low word", 64'(gpr_data), 64'hFFFD_B976);
      chk("R8", "acc untouched", {acc_hi, acc_lo}, 64'h3_8000);

      phase = "R5";
      issue(2'd0, 1'b0, 32'h0002_0000, 32'h0002_0000);
      issue(2'd0, 1'b0, 32'd1, 32'd1);
      idle(5);
      chk("R5", "issue during busy dropped", {acc_hi, acc_lo}, 64'h4_0000_0000);

      phase = "R3";
      issue(2'd0, 1'b0, 32'd1, 32'd2);
      issue(2'd1, 1'b0, 32'd3, 32'd4);
      issue(2'd1, 1'b0, 32'd5, 32'd6);
      issue(2'd2, 1'b0, 32'd1, 32'd1);
      idle(4);
      chk("R3", "back-to-back chain", {acc_hi, acc_lo}, 64'd43);

      phase = "R10";
      for (int i = 0; i < 400; i++) begin
         logic [31:0] a, b;
         a = $urandom();
         b = $urandom();
         if ($urandom_range(1, 0) == 1) b = {{16{b[15] & b[0]}}, b[15:0]};
         issue(2'($urandom_range(3, 0)), 1'($urandom_range(1, 0)), a, b);
      end
      idle(6);
      chk("R10", "random mix final", {acc_hi, acc_lo}, m_acc);

      finish_run();
   end
endmodule